// File: doc/BRIEF.md
# Heartbeat Watchdog with Extended Timeout

This block watches a heartbeat line driven by a processor. Each falling edge on the line restarts an internal count of clock cycles. If the count reaches the active timeout before the next falling edge arrives, the block raises a one-cycle fault pulse. A reset generator nearby turns that pulse into a system reset. The heartbeat and the mode-select line may be asynchronous to the block clock. Each passes through its own synchronizer, and edges are detected after synchronization.

The timeout is a base value given in clock cycles. A mode-select line picks between the base value and a value 128 times longer. Every edge on the mode-select line, rising or falling, restarts the count. While the reset generator holds reset asserted, the count stays at zero, and it starts counting in the first cycle after release. After a fault, the block waits for the reset that follows and does not count until that reset has been released. A base value of zero turns the watchdog off.

Top module: `hb_watchdog`

## Requirements
- R1: With mode low and base B nonzero, and no heartbeat activity, `fault_o` is high exactly at the B-th rising clock edge after `sys_reset_i` is released.
- R2: With mode high, the timeout is 128*B cycles, so `fault_o` rises at edge 128*B after release.
- R3: Only a falling edge of `heartbeat_i` restarts the count. `fault_o` then rises at edge limit+3 after the fall is applied: two synchronizer flops plus one edge flop. A rising edge does not restart the count.
- R4: Falling heartbeat edges spaced exactly `limit` cycles apart never cause a fault. A spacing of limit+1 cycles does cause one.
- R5: Each transition of `ext_mode_i`, in either direction, restarts the count, and the new mode's limit then applies. `fault_o` rises at edge newlimit+3 after the transition is applied.
- R6: While `sys_reset_i` is high the count stays at zero and `fault_o` stays low, however long that lasts.
- R7: A base value of zero disables the block, so no fault occurs. A nonzero base applied later starts counting at once.
- R8: `fault_o` is high for exactly one cycle. After a fault, no further fault occurs until `sys_reset_i` has been high and then released.
- R9: While `rst_n` is low, and directly after it, `fault_o` is low.
- R10: A heartbeat low pulse that lasts a single clock cycle is detected as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| heartbeat_i | input | 1 | Asynchronous heartbeat line; falling edges restart the count |
| ext_mode_i | input | 1 | Asynchronous mode line: low selects base timeout, high selects 128x |
| base_timeout_i | input | BASE_W | Base timeout in clock cycles; zero disables |
| sys_reset_i | input | 1 | Reset state from the reset generator, high while reset is asserted |
| fault_o | output | 1 | One-cycle pulse requesting a reset |

## Verification
The main function is driven with several patterns. A silent heartbeat in each mode checks the exact timeout length and the 128x scaling. A one-cycle low pulse partway through the timeout shows that a fall restarts the count and that the narrowest pulse is caught. A lone rising edge shows that rising edges are not confused with falls. A periodic heartbeat at exactly the limit and at one cycle past it checks the boundary between safe and faulting spacings. Toggling the mode line in both directions in the middle of a count separates a true restart from a mere change of limit.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic {
      WD_RUN  = 1'b0,
      WD_WAIT = 1'b1
   } wd_phase_e;

   localparam int unsigned WD_EXT_SHIFT_DEF = 7;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   input  logic [WIDTH-1:0] rst_val_i,
   output logic [WIDTH-1:0] lvl_o,
   output logic [WIDTH-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wdg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wdg_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{rst_val_i[b]}};
            last  <= rst_val_i[b];
         end else begin
            chain <= {chain[STAGES-2:0], raw_i[b]};
            last  <= chain[STAGES-1];
         end
      end
      assign lvl_o[b]  = chain[STAGES-1];
      assign prev_o[b] = last;
   end
endmodule

// File: rtl/wdg_limit.sv
module wdg_limit #(
   parameter int unsigned BASE_W    = 16,
   parameter int unsigned EXT_SHIFT = 7,
   localparam int unsigned CNT_W    = BASE_W + EXT_SHIFT
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic              ext_i,
   output logic              enabled_o,
   output logic [CNT_W-1:0]  limit_m1_o
);
   logic [CNT_W-1:0] base_wide;

   assign enabled_o = (base_i != '0);
   assign base_wide = CNT_W'(base_i);

   if (EXT_SHIFT == 0) begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_i;
      assign limit_m1_o = base_wide - CNT_W'(1);
   end else begin : g_ext
      logic [CNT_W-1:0] scaled;
      assign scaled     = base_wide << EXT_SHIFT;
      assign limit_m1_o = (ext_i ? scaled : base_wide) - CNT_W'(1);
   end
endmodule

// File: rtl/wdg_count.sv
module wdg_count
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_reset_i,
   input  logic             enabled_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] limit_m1_i,
   output logic             fault_o
);
   logic [CNT_W-1:0] cnt;
   wd_phase_e        phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         phase   <= WD_RUN;
         fault_o <= 1'b0;
      end else begin
         fault_o <= 1'b0;
         if (sys_reset_i) begin
            cnt   <= '0;
            phase <= WD_RUN;
         end else if (phase == WD_WAIT || !enabled_i || clear_i) begin
            cnt <= '0;
         end else if (cnt == limit_m1_i) begin
            cnt     <= '0;
            fault_o <= 1'b1;
            phase   <= WD_WAIT;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o);

   p_wait_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !sys_reset_i) |=> (cnt == '0));

   p_hold_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_i |=> (cnt == '0 && !fault_o));

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled_i |=> !fault_o);

   p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> ((cnt - $past(cnt)) == CNT_W'(1)));
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
   parameter int unsigned BASE_W      = 16,
   parameter int unsigned EXT_SHIFT   = wdg_pkg::WD_EXT_SHIFT_DEF,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              heartbeat_i,
   input  logic              ext_mode_i,
   input  logic [BASE_W-1:0] base_timeout_i,
   input  logic              sys_reset_i,
   output logic              fault_o
);
   localparam int unsigned CNT_W = BASE_W + EXT_SHIFT;

   if (BASE_W < 1) begin : g_bad_base
      $error("hb_watchdog: BASE_W must be at least 1");
   end

   logic [1:0]       lvl, prev;
   logic             hb_fall, mode_edge, enabled;
   logic [CNT_W-1:0] limit_m1;

   wdg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     ({ext_mode_i, heartbeat_i}),
      .rst_val_i (2'b01),
      .lvl_o     (lvl),
      .prev_o    (prev)
   );

   assign hb_fall   = prev[0] & ~lvl[0];
   assign mode_edge = prev[1] ^ lvl[1];

   wdg_limit #(.BASE_W(BASE_W), .EXT_SHIFT(EXT_SHIFT)) u_limit (
      .base_i     (base_timeout_i),
      .ext_i      (lvl[1]),
      .enabled_o  (enabled),
      .limit_m1_o (limit_m1)
   );

   wdg_count #(.CNT_W(CNT_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_reset_i (sys_reset_i),
      .enabled_i   (enabled),
      .clear_i     (hb_fall | mode_edge),
      .limit_m1_i  (limit_m1),
      .fault_o     (fault_o)
   );

   p_fault_needs_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $past(base_timeout_i != '0));
endmodule

// File: tb/hb_watchdog_tb.sv
module hb_watchdog_tb;
   localparam int BW = 16;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          heartbeat_i = 1'b1;
   logic          ext_mode_i = 1'b0;
   logic [BW-1:0] base_timeout_i = 16'd10;
   logic          sys_reset_i = 1'b1;
   logic          fault_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   hb_watchdog #(.BASE_W(BW)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .heartbeat_i    (heartbeat_i),
      .ext_mode_i     (ext_mode_i),
      .base_timeout_i (base_timeout_i),
      .sys_reset_i    (sys_reset_i),
      .fault_o        (fault_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wait_fault(input int max, output int n);
      n = 0;
      for (int i = 1; i <= max; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (fault_o && n == 0) n = i;
         if (n != 0) break;
      end
   endtask

   task automatic quiet(input int len, output int seen);
      seen = 0;
      for (int i = 0; i < len; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (fault_o) seen++;
      end
   endtask

   task automatic hold_reset(input int len);
      sys_reset_i = 1'b1;
      tick(len);
      sys_reset_i = 1'b0;
   endtask

   task automatic t_reset_state();
      check(fault_o == 1'b0, "R9 fault low in reset", fault_o, 0);
      rst_n = 1'b1;
      tick(2);
      check(fault_o == 1'b0, "R9 fault low after reset", fault_o, 0);
   endtask

   task automatic t_base_timeout();
      int n, seen;
      base_timeout_i = 16'd10;
      hold_reset(6);
      wait_fault(100, n);
      check(n == 10, "R1 base timeout", n, 10);
      tick(1);
      check(fault_o == 1'b0, "R8 single cycle", fault_o, 0);
      quiet(60, seen);
      check(seen == 0, "R8 no refault before reset", seen, 0);
      hold_reset(4);
      wait_fault(100, n);
      check(n == 10, "R8 counts again after reset", n, 10);
   endtask

   task automatic t_min_timeout();
      int n;
      base_timeout_i = 16'd1;
      hold_reset(6);
      wait_fault(20, n);
      check(n == 1, "R1 base of one", n, 1);
   endtask

   task automatic t_extended();
      int n;
      base_timeout_i = 16'd4;
      ext_mode_i = 1'b1;
      hold_reset(6);
      wait_fault(1000, n);
      check(n == 512, "R2 extended timeout", n, 512);
      ext_mode_i = 1'b0;
      hold_reset(6);
   endtask

   task automatic t_pulse_clears();
      int n;
      base_timeout_i = 16'd20;
      hold_reset(6);
      tick(15);
      heartbeat_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      heartbeat_i = 1'b1;
      wait_fault(200, n);
      n = n + 1;
      check(n == 20 + LAT, "R10 one-cycle pulse restarts count", n, 20 + LAT);
      check(n == 20 + LAT, "R3 timeout measured from fall", n, 20 + LAT);
   endtask

   task automatic t_rise_ignored();
      int n;
      base_timeout_i = 16'd20;
      heartbeat_i = 1'b0;
      hold_reset(6);
      tick(10);
      heartbeat_i = 1'b1;
      wait_fault(200, n);
      n = n + 10;
      check(n == 20, "R3 rising edge does not restart", n, 20);
   endtask

   task automatic pet_run(input int per, input int periods, output int seen);
      seen = 0;
      tick(1);
      for (int p = 0; p < periods; p++) begin
         heartbeat_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         if (fault_o) seen++;
         heartbeat_i = 1'b1;
         for (int i = 1; i < per; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (fault_o) seen++;
         end
      end
   endtask

   task automatic t_period_boundary();
      int seen;
      base_timeout_i = 16'd8;
      hold_reset(6);
      pet_run(8, 8, seen);
      check(seen == 0, "R4 period equal to limit is safe", seen, 0);
      hold_reset(6);
      pet_run(9, 6, seen);
      check(seen == 1, "R4 period one past limit faults", seen, 1);
   endtask

   task automatic t_mode_edges();
      int n;
      base_timeout_i = 16'd10;
      ext_mode_i = 1'b0;
      hold_reset(6);
      tick(5);
      ext_mode_i = 1'b1;
      wait_fault(2000, n);
      check(n == 1280 + LAT, "R5 rising mode edge restarts with 128x", n, 1280 + LAT);
      hold_reset(6);
      tick(100);
      ext_mode_i = 1'b0;
      wait_fault(2000, n);
      check(n == 10 + LAT, "R5 falling mode edge restarts with base", n, 10 + LAT);
   endtask

   task automatic t_reset_hold();
      int n, seen;
      base_timeout_i = 16'd10;
      sys_reset_i = 1'b1;
      quiet(50, seen);
      check(seen == 0, "R6 no fault while reset held", seen, 0);
      sys_reset_i = 1'b0;
      wait_fault(100, n);
      check(n == 10, "R6 counting starts on release", n, 10);
   endtask

   task automatic t_disable();
      int n, seen;
      base_timeout_i = '0;
      hold_reset(6);
      quiet(300, seen);
      check(seen == 0, "R7 zero base disables", seen, 0);
      base_timeout_i = 16'd10;
      wait_fault(100, n);
      check(n == 10, "R7 nonzero base resumes", n, 10);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      tick(3);
      t_reset_state();
      t_base_timeout();
      t_min_timeout();
      t_extended();
      t_pulse_clears();
      t_rise_ignored();
      t_period_boundary();
      t_mode_edges();
      t_reset_hold();
      t_disable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule